// File: doc/BRIEF.md
# Serial configuration bitstream reader

This block is the read-side controller of a serial configuration memory. It streams one bit per clock to a programmable logic device that loads its configuration in master serial mode. A single bit pointer walks the active region of a bit-addressed array. The array sits outside the block behind a synchronous read port that returns one byte per cycle. The loader supplies the clock and two active-low controls, `sel_n` and `rewind_n`. Together these gate the pointer and the output driver. The tri-state data pin is modelled as a value `sdo` plus an active-high enable `sdo_en`.

The active region is either the whole array or one quarter of it. The quarter is chosen by a two-bit bank number while bank splitting is on. Once the last bit of the region has been clocked out, the block releases its data output and pulls the cascade output `next_sel_n` low, which hands control to the next memory in a daisy chain. A read-mode input parks the read path while the array is being reprogrammed by other means. A synchronous power-on sequence holds the ready flag low for a set number of clocks.

The controller is a three-state machine. ST_POR is the power-on wait. ST_RUN is streaming or able to stream. ST_SPENT means the region is exhausted. Its transitions are:

- T_POR_DONE (ST_POR to ST_RUN): the power-on timer expires, and the pointer is loaded with the region start.
- T_RESTART (ST_RUN to ST_RUN): `rewind_n` is low, which reloads the region start.
- T_LAST_BIT (ST_RUN to ST_SPENT): an enabled clock arrives with the pointer on the region end.
- T_REARM (ST_SPENT to ST_RUN): `rewind_n` is low, which reloads the region start.

Top module: `cfgr_bitstream_reader`

## Requirements
- R1: After `rst` is released, `pwr_ok` stays 0 for exactly POR_CYCLES rising edges and then goes to 1. While it is 0, `sdo_en` is 0 and `next_sel_n` is 1.
- R2: With `read_mode` at 1 after power-up, `rewind_n` at 0 forces `sdo_en` to 0 at once, whatever the level of `sel_n`. The next rising edge loads the pointer with the start of the active region and leaves the spent condition.
- R3: With `read_mode` 1, `sel_n` 0 and `rewind_n` 1 in ST_RUN, `sdo_en` is 1 and `sdo` carries the bit at pointer address a. That bit is bit 7-(a mod 8) of array byte a/8, so bytes are sent MSB first. Each rising edge advances the pointer by one. `sdo` is 0 whenever `sdo_en` is 0.
- R4: With `sel_n` at 1 (standby), `sdo_en` is 0 and the pointer holds. When `sel_n` returns to 0, streaming resumes with the bit that was not yet sent.
- R5: With `bank_split` at 1, bank number k covers bit addresses k*P to k*P+P-1, where P = 2^(ADDR_BITS-2). A rewind starts the stream at k*P, and k*P+P-1 is the last bit sent.
- R6: With `bank_split` at 0, the region is the whole array, from address 0 to 2^ADDR_BITS-1.
- R7: After the last bit of the region has been clocked out, `sdo_en` is 0. Further clocks neither wrap nor move the pointer until `rewind_n` goes low.
- R8: In the spent condition with `read_mode` at 1, `next_sel_n` is low while `sel_n` is low and `rewind_n` is high, so it follows `sel_n`. Once `rewind_n` goes low, `next_sel_n` is high and stays high until the region has been read to its end again. Outside the spent condition it is high.
- R9: With `read_mode` at 0, `sdo_en` is 0, `next_sel_n` is 1, and the pointer and state do not change, whatever the levels of `sel_n`, `rewind_n`, `bank_split` and `bank_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the loading device |
| rst | input | 1 | Synchronous power-on reset, active high |
| read_mode | input | 1 | 1 selects read mode, 0 parks the read path for reprogramming |
| sel_n | input | 1 | Chip select, active low |
| rewind_n | input | 1 | Low rewinds the pointer and disables output; high permits output |
| bank_split | input | 1 | 1 splits the array into four banks |
| bank_id | input | 2 | Bank number used while bank splitting is on |
| mem_addr | output | ADDR_BITS-3 | Byte address of the array read port |
| mem_rdata | input | 8 | Array byte, registered, valid one cycle after its address |
| sdo | output | 1 | Serial configuration data |
| sdo_en | output | 1 | Output-driver enable for `sdo` |
| next_sel_n | output | 1 | Cascade select for the next device, active low |
| pwr_ok | output | 1 | Power-on sequence complete |

## Verification
The assertions take `bank_split` and `bank_id` as stable while the block is streaming or spent. The only changes they allow happen while `rewind_n` is low or `read_mode` is low. They also take the read port as returning the byte at `mem_addr` exactly one cycle later. The stimulus changes the bank inputs only inside a rewind pulse or a programming-mode window. It always restores them before returning to read mode, and its array model is a one-cycle registered read. Within those limits, the bench compares every output on every cycle against a behavioural model of pointer, region and cascade.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    // Bank number width: four banks when splitting is on.
    localparam int BANK_W = 2;

    typedef enum logic [1:0] {
        ST_POR   = 2'd0,
        ST_RUN   = 2'd1,
        ST_SPENT = 2'd2
    } cfgr_state_e;

endpackage

// File: rtl/cfgr_por.sv
module cfgr_por #(
    parameter int POR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    output logic por_expire
);
    localparam int CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign por_expire = (cnt == LAST);

    // R1: the timer climbs by one per clock until it saturates
    p_por_climb_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/cfgr_region.sv
module cfgr_region
    import cfgr_pkg::*;
#(
    parameter int ADDR_BITS = 8,
    parameter int PAGING_EN = 1
) (
    input  logic                 bank_split,
    input  logic [BANK_W-1:0]    bank_id,
    output logic [ADDR_BITS-1:0] region_lo,
    output logic [ADDR_BITS-1:0] region_hi
);
    localparam int OFF_W = ADDR_BITS - BANK_W;

    generate
        if (PAGING_EN != 0) begin : g_paged
            always_comb begin
                if (bank_split) begin
                    region_lo = {bank_id, {OFF_W{1'b0}}};
                    region_hi = {bank_id, {OFF_W{1'b1}}};
                end else begin
                    region_lo = '0;
                    region_hi = '1;
                end
            end
        end else begin : g_flat
            assign region_lo = '0;
            assign region_hi = '1;
        end
    endgenerate

endmodule

// File: rtl/cfgr_seq.sv
module cfgr_seq
    import cfgr_pkg::*;
#(
    parameter int ADDR_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por_expire,
    input  logic                 read_mode,
    input  logic                 sel_n,
    input  logic                 rewind_n,
    input  logic [ADDR_BITS-1:0] region_lo,
    input  logic [ADDR_BITS-1:0] region_hi,
    output logic [ADDR_BITS-4:0] byte_addr,
    output logic [2:0]           bit_pos,
    output logic                 sdo_en,
    output logic                 next_sel_n,
    output logic                 pwr_ok
);
    cfgr_state_e          st, st_d;
    logic [ADDR_BITS-1:0] ptr, ptr_d;
    logic                 go;

    assign go = read_mode & rewind_n & ~sel_n;

    // Next-state and next-pointer decode
    always_comb begin
        st_d  = st;
        ptr_d = ptr;
        unique case (st)
            ST_POR: begin
                ptr_d = region_lo;
                if (por_expire) st_d = ST_RUN;           // T_POR_DONE
            end
            ST_RUN: begin
                if (read_mode) begin
                    if (!rewind_n) begin
                        ptr_d = region_lo;               // T_RESTART
                    end else if (!sel_n) begin
                        if (ptr == region_hi) st_d = ST_SPENT; // T_LAST_BIT
                        else                  ptr_d = ptr + 1'b1;
                    end
                end
            end
            ST_SPENT: begin
                if (read_mode && !rewind_n) begin
                    ptr_d = region_lo;                   // T_REARM
                    st_d  = ST_RUN;
                end
            end
            default: st_d = ST_POR;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_POR;
            ptr <= '0;
        end else begin
            st  <= st_d;
            ptr <= ptr_d;
        end
    end

    // Outputs
    always_comb begin
        sdo_en     = 1'b0;
        next_sel_n = 1'b1;
        pwr_ok     = 1'b1;
        unique case (st)
            ST_POR:   pwr_ok     = 1'b0;
            ST_RUN:   sdo_en     = go;
            ST_SPENT: next_sel_n = ~go;
            default:  pwr_ok     = 1'b0;
        endcase
    end

    // Address the byte holding the next pointer so it arrives in time
    assign byte_addr = ptr_d[ADDR_BITS-1:3];
    assign bit_pos   = ptr[2:0];

    p_por_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_POR) |-> (!sdo_en && next_sel_n));

    p_rewind_load_r2: assert property (@(posedge clk) disable iff (rst)
        (st != ST_POR && read_mode && !rewind_n) |=>
            (ptr == $past(region_lo) && st == ST_RUN));

    p_standby_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (st != ST_POR && read_mode && rewind_n && sel_n) |=>
            ($stable(ptr) && $stable(st)));

    p_last_bit_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && go && ptr == region_hi) |=>
            (st == ST_SPENT && $stable(ptr)));

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SPENT && !(read_mode && !rewind_n)) |=>
            (st == ST_SPENT && $stable(ptr)));

    p_spent_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SPENT) |-> !sdo_en);

    p_cascade_spent_r8: assert property (@(posedge clk) disable iff (rst)
        !next_sel_n |-> (st == ST_SPENT && rewind_n && read_mode));

    p_prog_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (st != ST_POR && !read_mode) |=> ($stable(ptr) && $stable(st)));

    p_prog_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !read_mode |-> (!sdo_en && next_sel_n));

endmodule

// File: rtl/cfgr_bitstream_reader.sv
module cfgr_bitstream_reader
    import cfgr_pkg::*;
#(
    parameter int ADDR_BITS  = 8,
    parameter int POR_CYCLES = 4,
    parameter int PAGING_EN  = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 read_mode,
    input  logic                 sel_n,
    input  logic                 rewind_n,
    input  logic                 bank_split,
    input  logic [1:0]           bank_id,
    output logic [ADDR_BITS-4:0] mem_addr,
    input  logic [7:0]           mem_rdata,
    output logic                 sdo,
    output logic                 sdo_en,
    output logic                 next_sel_n,
    output logic                 pwr_ok
);
    logic                 por_expire;
    logic [ADDR_BITS-1:0] region_lo, region_hi;
    logic [2:0]           bit_pos;

    cfgr_por #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk        (clk),
        .rst        (rst),
        .por_expire (por_expire)
    );

    cfgr_region #(.ADDR_BITS(ADDR_BITS), .PAGING_EN(PAGING_EN)) u_region (
        .bank_split (bank_split),
        .bank_id    (bank_id),
        .region_lo  (region_lo),
        .region_hi  (region_hi)
    );

    cfgr_seq #(.ADDR_BITS(ADDR_BITS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .por_expire (por_expire),
        .read_mode  (read_mode),
        .sel_n      (sel_n),
        .rewind_n   (rewind_n),
        .region_lo  (region_lo),
        .region_hi  (region_hi),
        .byte_addr  (mem_addr),
        .bit_pos    (bit_pos),
        .sdo_en     (sdo_en),
        .next_sel_n (next_sel_n),
        .pwr_ok     (pwr_ok)
    );

    // MSB-first selection inside the byte
    assign sdo = sdo_en & mem_rdata[~bit_pos];

    p_sdo_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !sdo_en |-> !sdo);

    p_drive_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(sdo_en && !next_sel_n));

endmodule

// File: tb/sim_cfgr_bitstream_reader.sv
`timescale 1ns/1ps
module sim_cfgr_bitstream_reader;
    localparam int AB     = 8;
    localparam int POR    = 4;
    localparam int NBYTES = 1 << (AB - 3);
    localparam int PAGE   = 1 << (AB - 2);
    localparam int TOTAL  = 1 << AB;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, read_mode, sel_n, rewind_n, bank_split;
    logic [1:0]    bank_id;
    logic [AB-4:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic sdo, sdo_en, next_sel_n, pwr_ok;

    logic [7:0] mem [NBYTES];
    always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

    cfgr_bitstream_reader #(.ADDR_BITS(AB), .POR_CYCLES(POR), .PAGING_EN(1)) u0 (
        .clk(clk), .rst(rst), .read_mode(read_mode), .sel_n(sel_n),
        .rewind_n(rewind_n), .bank_split(bank_split), .bank_id(bank_id),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .sdo(sdo),
        .sdo_en(sdo_en), .next_sel_n(next_sel_n), .pwr_ok(pwr_ok)
    );

    int    m_ptr = 0;
    int    m_por = POR;
    bit    m_spent = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string req = "R1";

    function automatic int reg_lo();
        return bank_split ? int'(bank_id) * PAGE : 0;
    endfunction

    function automatic int reg_hi();
        return bank_split ? int'(bank_id) * PAGE + PAGE - 1 : TOTAL - 1;
    endfunction

    task automatic chk(string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // One clock: compare outputs, then advance the model at the edge
    task automatic cyc();
        logic e_rdy, e_en, e_cas, e_dat, go;
        #1;
        e_rdy = (m_por == 0);
        go    = e_rdy && read_mode && rewind_n && !sel_n;
        e_en  = go && !m_spent;
        e_cas = !(go && m_spent);
        e_dat = e_en ? mem[m_ptr / 8][7 - (m_ptr % 8)] : 1'b0;
        chk("pwr_ok", pwr_ok, e_rdy);
        chk("sdo_en", sdo_en, e_en);
        chk("next_sel_n", next_sel_n, e_cas);
        chk("sdo", sdo, e_dat);
        @(posedge clk);
        if (rst) begin
            m_por = POR; m_ptr = 0; m_spent = 0;
        end else if (m_por > 0) begin
            m_por--; m_ptr = reg_lo();
        end else if (read_mode) begin
            if (!rewind_n) begin
                m_ptr = reg_lo(); m_spent = 0;
            end else if (!sel_n && !m_spent) begin
                if (m_ptr == reg_hi()) m_spent = 1;
                else m_ptr++;
            end
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL %s watchdog: finished %0b expected 1", req, finished);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'((i * 29 + 7) ^ 8'h5A);
        rst = 1; read_mode = 1; sel_n = 1; rewind_n = 1; bank_split = 0; bank_id = 0;
        @(negedge clk);

        // R1: reset state and power-on wait
        req = "R1";
        repeat (3) cyc();
        rst = 0; sel_n = 0;
        repeat (POR + 2) cyc();

        // R2: rewind pulse with chip selected
        req = "R2";
        rewind_n = 0; cyc(); rewind_n = 1;

        // R6 / R3: whole array streamed MSB first
        req = "R6";
        repeat (TOTAL) cyc();

        // R7: terminal hold, no wrap
        req = "R7";
        repeat (6) cyc();

        // R8: cascade follows select, then stays high after rewind
        req = "R8";
        sel_n = 1; repeat (2) cyc();
        sel_n = 0; repeat (2) cyc();
        rewind_n = 0; cyc();
        rewind_n = 1; sel_n = 1; cyc();
        sel_n = 0; repeat (10) cyc();

        // R4: standby mid-stream then resume
        req = "R4";
        sel_n = 1; repeat (3) cyc();
        sel_n = 0; repeat (5) cyc();

        // R2: rewind while deselected
        req = "R2";
        sel_n = 1; rewind_n = 0; repeat (2) cyc();
        rewind_n = 1; sel_n = 0;
        req = "R3";
        repeat (8) cyc();

        // R5: each bank streamed to its end and beyond
        req = "R5";
        for (int k = 0; k < 4; k++) begin
            rewind_n = 0; bank_split = 1; bank_id = 2'(k); cyc();
            rewind_n = 1; sel_n = 0;
            repeat (PAGE + 3) cyc();
        end

        // R9: programming mode ignores every read control
        req = "R9";
        rewind_n = 0; bank_id = 2; cyc();
        rewind_n = 1; repeat (10) cyc();
        read_mode = 0; cyc();
        rewind_n = 0; cyc();
        sel_n = 1; bank_id = 1; bank_split = 0; repeat (3) cyc();
        sel_n = 0; rewind_n = 1; cyc();
        bank_split = 1; bank_id = 2; read_mode = 1;
        repeat (PAGE) cyc();

        finished = 1;
        summary();
        $finish;
    end
endmodule